// File: doc/BRIEF.md
# Serial Divider Configuration Loader

This block receives a divider setting for a clock synthesizer over three wires: a data line, a serial clock and a load strobe. A system clock samples all three wires through a synchronizer chain. A rising edge on the synchronized serial clock shifts one data bit into an 18-bit staging register. A rising edge on the synchronized load strobe copies the staged word into three held outputs: a 5-bit reference prescaler, a 3-bit post-divider code and a 10-bit feedback count.

On the wire, the prescaler goes first, most significant bit leading. The post-divider code follows, then the feedback count, which ends with its least significant bit. Only the post-divider code is checked. Codes 001 to 101 select ratios 2, 4, 8, 16 and 32. The codes 000, 110 and 111 are refused: the previous code stays in place and an error flag rises.

After reset the held outputs carry a usable setting: prescaler 11001, code 010, feedback 1001000000. The staging register is cleared.

Top module: `divcfg_loader`

## Requirements
- R1: While reset is active and after it is released, the held prescaler reads 11001, the code reads 010, the feedback count reads 1001000000, the ratio output reads 4 and the error flag reads 0.
- R2: Each rising serial clock shifts in one data bit. After 18 shifts, the first bit shifted ends up in prescaler bit 4 and the last in feedback bit 0. The order on the wire is prescaler bits 4..0, then code bits 2..0, then feedback bits 9..0.
- R3: Serial clock activity without a new rising load edge leaves every held output and the error flag unchanged.
- R4: One rising load edge commits exactly once. Shifting a new frame while the strobe stays high does not change the held outputs.
- R5: A commit whose code lies in 001..101 loads prescaler, code and feedback from the staged word and clears the error flag. The ratio output then equals 2 raised to the code.
- R6: A commit whose code is 000, 110 or 111 loads the prescaler and the feedback count, keeps the previous code and ratio, and sets the error flag.
- R7: When more than 18 bits arrive before a commit, only the last 18 are used.
- R8: Reset clears the staging register. A commit with no shifting after reset loads prescaler 0 and feedback 0, keeps code 010 and sets the error flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the serial wires |
| rst | input | 1 | Synchronous active-high reset |
| ser_data | input | 1 | Serial data bit |
| ser_clk | input | 1 | Serial clock; a bit is taken on its rising edge |
| ser_load | input | 1 | Commit strobe; acts on its rising edge |
| pre_div | output | 5 | Held reference prescaler value |
| out_code | output | 3 | Held post-divider code (always legal) |
| fb_div | output | 10 | Held feedback divider value |
| out_ratio | output | 6 | Post-divider ratio decoded from out_code |
| code_err | output | 1 | High when the last commit carried an illegal code |

## Verification
The bench sweeps all eight post-divider codes. Each frame in the sweep carries a prescaler and feedback pattern derived arithmetically from the code, so a field that is swapped or bit-reversed shows up as a wrong value in a field that is still loaded. The two standard synthesizer settings are loaded as well. Other patterns separate the edge behaviour from the level behaviour: a commit straight out of reset, a frame shifted while the strobe stays high, and a 20-bit frame. These tell apart edge triggering from level triggering, kept codes from overwritten codes, and a cleared staging register from one left stale.

// File: rtl/divcfg_pkg.sv
package divcfg_pkg;

    localparam int PRE_W   = 5;
    localparam int CODE_W  = 3;
    localparam int FB_W    = 10;
    localparam int FRAME_W = PRE_W + CODE_W + FB_W;
    localparam int RATIO_W = 6;

    // Field order matches wire order: first bit shifted is the struct MSB.
    typedef struct packed {
        logic [PRE_W-1:0]  pre;
        logic [CODE_W-1:0] code;
        logic [FB_W-1:0]   fb;
    } divcfg_t;

    localparam divcfg_t CFG_RESET = '{pre: 5'b11001, code: 3'b010, fb: 10'b1001000000};

    function automatic logic code_ok(input logic [CODE_W-1:0] c);
        return (c >= 3'd1) && (c <= 3'd5);
    endfunction

    function automatic logic [RATIO_W-1:0] code_ratio(input logic [CODE_W-1:0] c);
        return code_ok(c) ? (RATIO_W'(1) << c) : '0;
    endfunction

endpackage

// File: rtl/divcfg_sync.sv
module divcfg_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= '0;
        else     chain[0] <= d;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain[i] <= '0;
            else     chain[i] <= chain[i-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/divcfg_rise.sv
module divcfg_rise #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] rise
);
    logic [W-1:0] prev;

    always_ff @(posedge clk) begin
        if (rst) prev <= '0;
        else     prev <= lvl;
    end

    assign rise = lvl & ~prev;

    for (genvar i = 0; i < W; i++) begin : g_chk
        assert_one_pulse_R4: assert property (@(posedge clk) disable iff (rst)
            rise[i] |=> !rise[i]);
    end
endmodule

// File: rtl/divcfg_shift.sv
module divcfg_shift
    import divcfg_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               en,
    input  logic               din,
    output logic [FRAME_W-1:0] word
);
    always_ff @(posedge clk) begin
        if (rst)     word <= '0;
        else if (en) word <= {word[FRAME_W-2:0], din};
    end

    assert_shift_R2: assert property (@(posedge clk) disable iff (rst)
        en |=> (word[0] == $past(din)) && (word[FRAME_W-1:1] == $past(word[FRAME_W-2:0])));
    assert_idle_R3: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(word));
endmodule

// File: rtl/divcfg_hold.sv
module divcfg_hold
    import divcfg_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    commit,
    input  divcfg_t frame,
    output divcfg_t cfg,
    output logic    err
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= CFG_RESET;
            err <= 1'b0;
        end else if (commit) begin
            cfg.pre <= frame.pre;
            cfg.fb  <= frame.fb;
            if (code_ok(frame.code)) begin
                cfg.code <= frame.code;
                err      <= 1'b0;
            end else begin
                err      <= 1'b1;
            end
        end
    end

    assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !commit |=> $stable(cfg) && $stable(err));
    assert_legal_R5: assert property (@(posedge clk) disable iff (rst)
        code_ok(cfg.code));
    assert_good_R5: assert property (@(posedge clk) disable iff (rst)
        (commit && code_ok(frame.code)) |=> !err && (cfg == $past(frame)));
    assert_bad_R6: assert property (@(posedge clk) disable iff (rst)
        (commit && !code_ok(frame.code)) |=> err && (cfg.code == $past(cfg.code))
            && (cfg.pre == $past(frame.pre)) && (cfg.fb == $past(frame.fb)));
endmodule

// File: rtl/divcfg_loader.sv
module divcfg_loader
    import divcfg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ser_data,
    input  logic               ser_clk,
    input  logic               ser_load,
    output logic [PRE_W-1:0]   pre_div,
    output logic [CODE_W-1:0]  out_code,
    output logic [FB_W-1:0]    fb_div,
    output logic [RATIO_W-1:0] out_ratio,
    output logic               code_err
);
    logic [2:0]         wires_s;
    logic [1:0]         edges;
    logic [FRAME_W-1:0] staged;
    divcfg_t            held;

    divcfg_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({ser_load, ser_clk, ser_data}),
        .q   (wires_s)
    );

    divcfg_rise #(.W(2)) u_rise (
        .clk  (clk),
        .rst  (rst),
        .lvl  (wires_s[2:1]),
        .rise (edges)
    );

    divcfg_shift u_shift (
        .clk  (clk),
        .rst  (rst),
        .en   (edges[0]),
        .din  (wires_s[0]),
        .word (staged)
    );

    divcfg_hold u_hold (
        .clk    (clk),
        .rst    (rst),
        .commit (edges[1]),
        .frame  (divcfg_t'(staged)),
        .cfg    (held),
        .err    (code_err)
    );

    assign pre_div   = held.pre;
    assign out_code  = held.code;
    assign fb_div    = held.fb;
    assign out_ratio = code_ratio(held.code);
endmodule

// File: tb/divcfg_loader_test.sv
module divcfg_loader_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ser_data = 1'b0, ser_clk = 1'b0, ser_load = 1'b0;
    logic [4:0] pre_div;
    logic [2:0] out_code;
    logic [9:0] fb_div;
    logic [5:0] out_ratio;
    logic       code_err;

    int checks = 0, fails = 0;
    bit done = 0;

    logic [4:0] e_pre;
    logic [2:0] e_code;
    logic [9:0] e_fb;
    logic       e_err;

    always #10 clk = ~clk;

    divcfg_loader uut (
        .clk(clk), .rst(rst), .ser_data(ser_data), .ser_clk(ser_clk), .ser_load(ser_load),
        .pre_div(pre_div), .out_code(out_code), .fb_div(fb_div),
        .out_ratio(out_ratio), .code_err(code_err)
    );

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_all(input string tag);
        chk({tag, " prescaler"}, 16'(pre_div), 16'(e_pre));
        chk({tag, " code"},      16'(out_code), 16'(e_code));
        chk({tag, " feedback"},  16'(fb_div), 16'(e_fb));
        chk({tag, " ratio"},     16'(out_ratio), 16'(1) << e_code);
        chk({tag, " error"},     16'(code_err), 16'(e_err));
    endtask

    task automatic send_bit(input logic b);
        ser_data = b;
        wait_cyc(2);
        ser_clk = 1'b1;
        wait_cyc(3);
        ser_clk = 1'b0;
        wait_cyc(3);
    endtask

    task automatic send_frame(input logic [17:0] f);
        for (int i = 17; i >= 0; i--) send_bit(f[i]);
    endtask

    task automatic pulse_load();
        ser_load = 1'b1;
        wait_cyc(4);
        ser_load = 1'b0;
        wait_cyc(4);
    endtask

    task automatic expect_commit(input logic [4:0] p, input logic [2:0] c, input logic [9:0] m);
        e_pre = p;
        e_fb  = m;
        if (c >= 3'd1 && c <= 3'd5) begin
            e_code = c;
            e_err  = 1'b0;
        end else begin
            e_err  = 1'b1;
        end
    endtask

    initial begin
        e_pre = 5'b11001; e_code = 3'b010; e_fb = 10'b1001000000; e_err = 1'b0;
        wait_cyc(2);
        chk_all("R1 in reset");
        wait_cyc(1);
        rst = 1'b0;
        wait_cyc(3);
        chk_all("R1 after reset");

        // R8: commit with an empty staging register
        pulse_load();
        expect_commit(5'd0, 3'd0, 10'd0);
        chk_all("R8 empty commit");

        // 155.52 MHz setting; R3 before the strobe, R2/R5 after
        send_frame({5'b11001, 3'b010, 10'b1001000000});
        chk_all("R3 shifted not loaded");
        pulse_load();
        expect_commit(5'b11001, 3'b010, 10'b1001000000);
        chk_all("R2 R5 setting A");

        // 125 MHz setting
        send_frame({5'b11011, 3'b010, 10'b0111110100});
        pulse_load();
        expect_commit(5'b11011, 3'b010, 10'b0111110100);
        chk_all("R2 R5 setting B");

        // sweep every code with arithmetic field patterns
        for (int c = 0; c < 8; c++) begin
            logic [4:0] p;
            logic [9:0] m;
            p = 5'((c * 7 + 3) % 32);
            m = 10'((c * 173 + 41) % 1024);
            send_frame({p, 3'(c), m});
            chk_all("R3 sweep before strobe");
            pulse_load();
            expect_commit(p, 3'(c), m);
            chk_all((c >= 1 && c <= 5) ? "R5 sweep valid" : "R6 sweep invalid");
        end

        // R4: strobe held high across a new frame
        ser_load = 1'b1;
        wait_cyc(4);
        send_frame({5'b10101, 3'b100, 10'b1100110011});
        chk_all("R4 held strobe");
        ser_load = 1'b0;
        wait_cyc(4);
        chk_all("R4 strobe released");
        pulse_load();
        expect_commit(5'b10101, 3'b100, 10'b1100110011);
        chk_all("R4 fresh edge");

        // R7: two extra leading bits are pushed out
        send_bit(1'b1);
        send_bit(1'b0);
        send_frame({5'b01110, 3'b001, 10'b0000011111});
        pulse_load();
        expect_commit(5'b01110, 3'b001, 10'b0000011111);
        chk_all("R7 long frame");

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule